// File: doc/BRIEF.md
# Synchronous Rectifier Trigger Pulse Generator

This block sits on the primary side of a two-switch forward converter. It takes the pulse-width-modulated gate command from a PWM controller and produces three clocked outputs. The first is a delayed copy of the command that drives the primary switches. The second is a fixed-width pulse that tells the secondary side to switch its rectifiers off. The third is a fixed-width pulse that tells the secondary side to switch them on. Every duration is a parameter counted in clock cycles, apart from one delay, which a configuration input sets.

The turn-on pulse has two sources. One is a programmable delay after the drive output rises. The other is a falling edge on a synchronized winding-detect input. A winding-detect request that arrives while the turn-off pulse is high is held, and it fires once that pulse has ended. Both sources are blocked in two cases: when the duty cycle measured over the last command period is below a threshold percentage (light load), and when the drive output has stayed high for longer than a maximum on-time. An enable input from a supervisor clears the whole block and forces every output low.

Top module: `sr_trig_gen`

## Requirements
- R1: After the command input goes high, `drive_out` rises on the RISE_DLY-th clock edge, counted from the first edge that samples the high level. A high level that lasts fewer than RISE_DLY cycles never raises `drive_out`.
- R2: After the command input goes low, `drive_out` falls on the FALL_DLY-th clock edge, counted from the first edge that samples the low level.
- R3: Every rising and every falling command edge starts an `off_trig_out` pulse. The pulse rises on the (OFF_DLY+1)-th edge after the changed level is first sampled, and stays high for OFF_WIDTH cycles.
- R4: `on_trig_out` rises N edges after `drive_out` rises, where N is the value of `on_dly_cfg` and a value of 0 behaves as 1. The pulse stays high for ON_WIDTH cycles.
- R5: A high-to-low change of `det_in` fires `on_trig_out` on the (DET_DLY+1)-th edge after the low level is first sampled, provided `off_trig_out` is low at that point.
- R6: A winding-detect request that would fire while `off_trig_out` is high is held pending. `on_trig_out` then rises one cycle after `off_trig_out` falls.
- R7: At each rising command edge, the period that just ended is judged, using H high cycles and P total cycles. If P is at least MIN_PERIOD, light-load mode is set when H*100 < P*LIGHT_PCT and cleared otherwise. A duty of exactly LIGHT_PCT does not set it. A period shorter than MIN_PERIOD leaves the mode unchanged. The first rising edge after reset or enable only starts a measurement. While light-load mode is set, no turn-on pulse starts, and turn-off pulses continue.
- R8: While `drive_out` has been high for MAX_ON cycles or more, no turn-on pulse starts from either source. The block stays in this state until `drive_out` goes low.
- R9: A trigger that arrives while its pulse is already high restarts the width count. The pulse then ends its full width after the newest trigger.
- R10: When `en` is low, all three outputs are low in the same cycle. All counters, pending requests and the light-load state are cleared.
- R11: During reset and right after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Supervisor enable; low clears the block and forces the outputs low |
| cmd_in | input | 1 | Synchronized PWM gate command |
| det_in | input | 1 | Synchronized winding-detect level; a high-to-low change requests a turn-on pulse |
| on_dly_cfg | input | DLY_W | Turn-on delay after the drive rises, in cycles (0 acts as 1) |
| drive_out | output | 1 | Delayed gate drive for the primary switches |
| on_trig_out | output | 1 | Rectifier turn-on trigger pulse |
| off_trig_out | output | 1 | Rectifier turn-off trigger pulse |

## Verification
A wrong delay count or width count appears at the ports within one switching period. A pulse edge lands on the wrong cycle, or a short command is not filtered. A wrong light-load decision stays hidden until the next command period: the turn-on pulse of that period is then missing or extra, so the bench checks the period after each boundary duty. A stale pending request or an uncleared maximum-on state shows up as a turn-on pulse at the wrong moment, or no pulse at all, in the cycles just after the turn-off pulse ends or after enable returns.

// File: rtl/sr_trig_pkg.sv
package sr_trig_pkg;

    // Light-load decision: high time is below pct percent of the period.
    function automatic logic duty_below(input logic [31:0] hi_cyc,
                                        input logic [31:0] per_cyc,
                                        input logic [31:0] pct);
        return (hi_cyc * 32'd100) < (per_cyc * pct);
    endfunction

endpackage

// File: rtl/sr_drive_delay.sv
module sr_drive_delay #(
    parameter int unsigned RISE_DLY = 75,
    parameter int unsigned FALL_DLY = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmd,
    output logic drive,
    output logic rise_stb
);
    localparam int unsigned MAXD = (RISE_DLY > FALL_DLY) ? RISE_DLY : FALL_DLY;
    localparam int W = $clog2(MAXD + 1);
    localparam logic [W-1:0] RISE_T = W'(RISE_DLY - 1);
    localparam logic [W-1:0] FALL_T = W'(FALL_DLY - 1);

    typedef struct packed {
        logic         drive;
        logic [W-1:0] cnt;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_stb = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (cmd != st_q.drive) begin
            if (st_q.cnt == (cmd ? RISE_T : FALL_T)) begin
                st_d.drive = cmd;
                st_d.cnt   = '0;
                rise_stb   = cmd;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive = st_q.drive;

    AST_DRIVE_RISE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.drive) |-> $past(cmd)); // R1
    AST_DRIVE_FALL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.drive) |-> (!$past(cmd) || $past(clr))); // R2

endmodule

// File: rtl/sr_event_delay.sv
module sr_event_delay #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          trig,
    input  logic [DW-1:0] dly,
    output logic          fire
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (trig) begin
            st_d.cnt = (dly == '0) ? DW'(1) : dly;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = (st_q.cnt == DW'(1));

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || $past(trig))); // R4

endmodule

// File: rtl/sr_pulse_timer.sv
module sr_pulse_timer #(
    parameter int unsigned WIDTH = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic pulse
);
    localparam int W = $clog2(WIDTH + 1);
    localparam logic [W-1:0] LOAD = W'(WIDTH - 1);

    typedef struct packed {
        logic         pulse;
        logic [W-1:0] cnt;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (fire) begin
            st_d.pulse = 1'b1;
            st_d.cnt   = LOAD;
        end else if (st_q.pulse) begin
            if (st_q.cnt == '0) st_d.pulse = 1'b0;
            else                st_d.cnt   = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    AST_PULSE_START_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pulse) |-> $past(fire)); // R3
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && st_q.cnt != '0 && !clr) |=> st_q.pulse); // R9

endmodule

// File: rtl/sr_duty_monitor.sv
module sr_duty_monitor #(
    parameter int          CNT_W      = 16,
    parameter int unsigned LIGHT_PCT  = 10,
    parameter int unsigned MIN_PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmd,
    input  logic rise_stb,
    output logic light
);
    import sr_trig_pkg::*;

    typedef struct packed {
        logic             armed;
        logic             light;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] per;
    } duty_st_t;

    duty_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (rise_stb) begin
            if (st_q.armed && (32'(st_q.per) >= MIN_PERIOD))
                st_d.light = duty_below(32'(st_q.hi), 32'(st_q.per), LIGHT_PCT);
            st_d.armed = 1'b1;
            st_d.per   = CNT_W'(1);
            st_d.hi    = CNT_W'(1);
        end else begin
            if (st_q.per != '1)        st_d.per = st_q.per + 1'b1;
            if (cmd && st_q.hi != '1)  st_d.hi  = st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign light = st_q.light;

    AST_LIGHT_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.light) |-> ($past(rise_stb) || $past(clr))); // R7

endmodule

// File: rtl/sr_trig_gen.sv
module sr_trig_gen #(
    parameter int unsigned RISE_DLY   = 75,
    parameter int unsigned FALL_DLY   = 25,
    parameter int unsigned OFF_DLY    = 12,
    parameter int unsigned OFF_WIDTH  = 75,
    parameter int unsigned ON_WIDTH   = 175,
    parameter int unsigned DET_DLY    = 12,
    parameter int unsigned MAX_ON     = 2500,
    parameter int unsigned LIGHT_PCT  = 10,
    parameter int unsigned MIN_PERIOD = 64,
    parameter int          CNT_W      = 16,
    parameter int          DLY_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cmd_in,
    input  logic             det_in,
    input  logic [DLY_W-1:0] on_dly_cfg,
    output logic             drive_out,
    output logic             on_trig_out,
    output logic             off_trig_out
);
    localparam int ONW    = $clog2(MAX_ON + 1);
    localparam int OFF_DW = $clog2(OFF_DLY + 1);
    localparam int DET_DW = $clog2(DET_DLY + 1);

    typedef struct packed {
        logic           cmd;
        logic           det;
        logic           pend;
        logic [ONW-1:0] on_cnt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic clr, cmd_edge, cmd_rise, det_fall;
    logic drv_q, drv_rise, fire_off, fire_prog, fire_det;
    logic off_q, on_q, light, max_hit;
    logic suppress, det_req, on_fire;

    assign clr      = ~en;
    assign cmd_edge = cmd_in ^ st_q.cmd;
    assign cmd_rise = cmd_in & ~st_q.cmd;
    assign det_fall = st_q.det & ~det_in;
    assign max_hit  = (st_q.on_cnt == ONW'(MAX_ON));

    sr_drive_delay #(.RISE_DLY(RISE_DLY), .FALL_DLY(FALL_DLY)) u_drive (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd_in),
        .drive(drv_q), .rise_stb(drv_rise));

    sr_event_delay #(.DW(OFF_DW)) u_off_dly (
        .clk(clk), .rst_n(rst_n), .clr(clr), .trig(cmd_edge),
        .dly(OFF_DW'(OFF_DLY)), .fire(fire_off));

    sr_event_delay #(.DW(DLY_W)) u_on_dly (
        .clk(clk), .rst_n(rst_n), .clr(clr), .trig(drv_rise),
        .dly(on_dly_cfg), .fire(fire_prog));

    sr_event_delay #(.DW(DET_DW)) u_det_dly (
        .clk(clk), .rst_n(rst_n), .clr(clr), .trig(det_fall),
        .dly(DET_DW'(DET_DLY)), .fire(fire_det));

    sr_duty_monitor #(.CNT_W(CNT_W), .LIGHT_PCT(LIGHT_PCT), .MIN_PERIOD(MIN_PERIOD)) u_duty (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd_in),
        .rise_stb(cmd_rise), .light(light));

    always_comb begin
        suppress = light | max_hit;
        det_req  = fire_det | st_q.pend;
        on_fire  = ~suppress & (fire_prog | (det_req & ~off_q));
        st_d      = st_q;
        st_d.cmd  = cmd_in;
        st_d.det  = det_in;
        st_d.pend = det_req & off_q & ~suppress;
        if (!drv_q)        st_d.on_cnt = '0;
        else if (!max_hit) st_d.on_cnt = st_q.on_cnt + 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sr_pulse_timer #(.WIDTH(OFF_WIDTH)) u_off_pls (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire_off), .pulse(off_q));

    sr_pulse_timer #(.WIDTH(ON_WIDTH)) u_on_pls (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(on_fire), .pulse(on_q));

    assign drive_out    = drv_q & en;
    assign on_trig_out  = on_q  & en;
    assign off_trig_out = off_q & en;

    AST_ON_BLOCKED_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |-> !$past(light)); // R7
    AST_ON_BLOCKED_MAXON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |-> !$past(max_hit)); // R8
    AST_DET_WAITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on_q) && !$past(fire_prog)) |-> !$past(off_q)); // R6
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drv_q && !off_q && !on_q && !st_q.pend)); // R10

endmodule

// File: tb/test_sr_trig_gen.sv
`timescale 1ns/1ps
module test_sr_trig_gen;
    localparam int B_RISE = 6, B_FALL = 3, B_OFFD = 2, B_OFFW = 5, B_ONW = 8;
    localparam int B_DETD = 2, B_MAXON = 40, B_PCT = 10, B_MINP = 8;

    localparam int NV = 10;
    localparam int V_P [NV]     = '{40, 30, 50, 40, 100, 40, 100, 6, 40, 40};
    localparam int V_H [NV]     = '{20, 12,  4, 20,  10, 20,   9, 3, 20, 20};
    localparam int V_N [NV]     = '{ 3,  0,  2,  5,   2,  2,   2, 2,  2,  2};
    localparam int V_PLAIN [NV] = '{ 1,  1,  1,  1,   1,  1,   1, 0,  0,  1};

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, cmd = 1'b0, det = 1'b0;
    logic [7:0] cfg = 8'd0;
    logic drv, onp, offp;
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 0;

    int m_drv_rises, m_drv_rise_t, m_drv_fall_t;
    int m_off_rises, m_off_t0, m_off_t1, m_off_last, m_off_w;
    int m_on_rises, m_on_t, m_on_last, m_on_w;
    logic p_drv = 0, p_on = 0, p_off = 0;

    sr_trig_gen #(.RISE_DLY(B_RISE), .FALL_DLY(B_FALL), .OFF_DLY(B_OFFD), .OFF_WIDTH(B_OFFW),
                  .ON_WIDTH(B_ONW), .DET_DLY(B_DETD), .MAX_ON(B_MAXON), .LIGHT_PCT(B_PCT),
                  .MIN_PERIOD(B_MINP), .CNT_W(16), .DLY_W(8)) i_sr_trig_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd_in(cmd), .det_in(det), .on_dly_cfg(cfg),
        .drive_out(drv), .on_trig_out(onp), .off_trig_out(offp));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (drv && !p_drv) begin m_drv_rises++; m_drv_rise_t = cyc; end
        if (!drv && p_drv) m_drv_fall_t = cyc;
        if (offp && !p_off) begin
            m_off_rises++; m_off_last = cyc;
            if (m_off_rises == 1) m_off_t0 = cyc; else m_off_t1 = cyc;
        end
        if (!offp && p_off) m_off_w = cyc - m_off_last;
        if (onp && !p_on) begin
            m_on_rises++; m_on_last = cyc;
            if (m_on_rises == 1) m_on_t = cyc;
        end
        if (!onp && p_on) m_on_w = cyc - m_on_last;
        p_drv = drv; p_off = offp; p_on = onp;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clr_mon();
        m_drv_rises = 0; m_drv_rise_t = -1; m_drv_fall_t = -1;
        m_off_rises = 0; m_off_t0 = -1; m_off_t1 = -1; m_off_w = -1;
        m_on_rises = 0; m_on_t = -1; m_on_w = -1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b1; cmd = 1'b0; det = 1'b0;
        repeat (3) step();
        chk("R11 drive low in reset", int'(drv), 0);
        chk("R11 on low in reset", int'(onp), 0);
        chk("R11 off low in reset", int'(offp), 0);
        rst_n = 1'b1;
        step();
        chk("R11 outputs low after reset", int'({drv, onp, offp}), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, td;
        int prev_p = 0, prev_h = 0;
        bit armed_m = 0, light_m = 0;
        clr_mon();
        do_reset();

        // Table of command periods with expected timing
        for (int i = 0; i < NV; i++) begin
            int p = V_P[i], h = V_H[i], n = V_N[i];
            bit exp_on;
            if (armed_m && prev_p >= B_MINP) light_m = (prev_h * 100 < prev_p * B_PCT);
            armed_m = 1; prev_p = p; prev_h = h;
            exp_on = (h >= B_RISE) && !light_m;
            t0 = cyc; clr_mon();
            cfg = 8'(n); cmd = 1'b1;
            repeat (h) step();
            cmd = 1'b0;
            repeat (p - h) step();
            if (h >= B_RISE) begin
                chk($sformatf("R1 vec%0d drive rise", i), m_drv_rise_t, t0 + B_RISE);
                chk($sformatf("R2 vec%0d drive fall", i), m_drv_fall_t, t0 + h + B_FALL);
            end else begin
                chk($sformatf("R1 vec%0d short cmd filtered", i), m_drv_rises, 0);
            end
            if (V_PLAIN[i] != 0) begin
                chk($sformatf("R3 vec%0d off rise", i), m_off_t0, t0 + B_OFFD + 1);
                if (h > B_OFFW) begin
                    chk($sformatf("R3 vec%0d off count", i), m_off_rises, 2);
                    chk($sformatf("R3 vec%0d off second rise", i), m_off_t1, t0 + h + B_OFFD + 1);
                    chk($sformatf("R3 vec%0d off width", i), m_off_w, B_OFFW);
                end else begin
                    chk($sformatf("R9 vec%0d off merged count", i), m_off_rises, 1);
                    chk($sformatf("R9 vec%0d off restarted width", i), m_off_w, h + B_OFFW);
                end
                if (light_m) chk($sformatf("R7 vec%0d off continues", i), int'(m_off_rises > 0), 1);
            end
            chk($sformatf("%s vec%0d on count", light_m ? "R7" : "R4", i), m_on_rises, exp_on ? 1 : 0);
            if (exp_on) begin
                chk($sformatf("R4 vec%0d on rise", i), m_on_t, t0 + B_RISE + ((n == 0) ? 1 : n));
                chk($sformatf("R4 vec%0d on width", i), m_on_w, B_ONW);
            end
        end

        // R8 max on-time then R5 detect edge with drive low
        do_reset();
        cfg = 8'd2; cmd = 1'b1;
        repeat (60) step();
        det = 1'b1; step(); det = 1'b0; td = cyc; clr_mon();
        repeat (20) step();
        chk("R8 no on pulse past max on-time", m_on_rises, 0);
        cmd = 1'b0;
        repeat (20) step();
        det = 1'b1; step(); det = 1'b0; td = cyc; clr_mon();
        repeat (15) step();
        chk("R5 detect on count", m_on_rises, 1);
        chk("R5 detect on rise", m_on_t, td + B_DETD + 1);
        chk("R5 detect on width", m_on_w, B_ONW);

        // R6 detect request held during off pulse
        do_reset();
        cfg = 8'd20; det = 1'b1; step();
        cmd = 1'b1; t0 = cyc; clr_mon();
        step(); step();
        det = 1'b0;
        repeat (20) step();
        chk("R6 off pulse rise", m_off_t0, t0 + B_OFFD + 1);
        chk("R6 pending on rise after off", m_on_t, t0 + B_OFFD + 1 + B_OFFW + 1);

        // R10 enable drop clears pending and forces outputs low
        do_reset();
        cfg = 8'd20; det = 1'b1; step();
        cmd = 1'b1; t0 = cyc;
        step(); step();
        det = 1'b0;
        repeat (4) step();
        chk("R10 drive high before disable", int'(drv), 1);
        en = 1'b0; #1;
        chk("R10 drive forced low", int'(drv), 0);
        chk("R10 off forced low", int'(offp), 0);
        chk("R10 on forced low", int'(onp), 0);
        cmd = 1'b0;
        repeat (3) step();
        en = 1'b1; clr_mon();
        repeat (30) step();
        chk("R10 no stale on pulse", m_on_rises, 0);
        chk("R10 no off pulse", m_off_rises, 0);
        chk("R10 no drive", m_drv_rises, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule